// File: doc/BRIEF.md
# Dual Page-Size Instruction Address Translator

This block maps instruction-fetch virtual addresses to physical addresses. It holds two fully associative translation arrays side by side: one of eight entries for 8 KB pages and one of four entries for 4 MB pages. A lookup searches both arrays at the same time. The matching entry's frame number is joined to the page offset, and the hit, miss and physical address appear in registers one cycle after the lookup is presented.

New translations arrive on a fill port, and a page-size select steers them to one array. Each array keeps the index of its most recently used entry, meaning the last entry that hit or was filled. The fill victim is the lowest-numbered empty entry. When the array is full, a rotating pointer picks the victim and steps over the most recently used entry. A single flush input empties both arrays in one cycle.

Top module: `instr_xlate_buf`

## Requirements
- R1: After reset, `xl_hit` and `xl_miss` are low, `xl_pa` is zero, and every entry is empty, so any lookup misses.
- R2: A lookup that matches a small-page entry returns `{frame[20:0], VA[12:0]}` one cycle later. The small tag is VA[42:13] and is compared against the filled `fill_vpn[29:0]`.
- R3: A lookup that matches a large-page entry returns `{fill_pfn[20:9], VA[21:0]}` one cycle later. The large tag is VA[42:22] and is compared against the filled `fill_vpn[29:9]`. A fill with `fill_large`=1 writes the large array only.
- R4: `xl_miss` is high one cycle after a valid lookup that matches no entry in either array. Both `xl_hit` and `xl_miss` are low one cycle after a cycle with no valid lookup.
- R5: When both arrays match, the large-page translation is returned.
- R6: A fill writes the lowest-numbered empty entry of its array if one exists.
- R7: When the array is full, the victim is the rotating pointer. If the pointer equals the most recently used index (the last hit or fill), the next index is taken instead. After the fill the pointer moves to the entry after the victim.
- R8: `flush_all` empties both arrays in one cycle and resets their pointers. A fill in the same cycle is dropped.
- R9: `xl_hit` and `xl_miss` are never both high, and `xl_pa` is zero whenever `xl_hit` is low.
- R10: A lookup in the same cycle as a fill or flush sees the array contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_va | input | 43 | Lookup virtual address |
| fill_en | input | 1 | Write a new translation |
| fill_large | input | 1 | 1 selects the 4 MB array, 0 the 8 KB array |
| fill_vpn | input | 30 | Virtual page number, VA[42:13] |
| fill_pfn | input | 21 | Physical frame number, PA[33:13] |
| flush_all | input | 1 | Empty both arrays |
| xl_hit | output | 1 | Registered hit |
| xl_miss | output | 1 | Registered miss |
| xl_pa | output | 34 | Registered physical address |

## Verification
The assertions assume that a page already present in an array is never filled into that same array again, so no more than one entry of an array can match. The same page may be present in both arrays, and that case is the priority being tested. The stimulus draws every fill from counters that only ever increase, one per array, which keeps fills unique within each array. A behavioural reference model of both arrays and their replacement state is compared with the outputs on every clock. Directed sequences force the pointer onto the most recently used index and overlap a flush or a lookup with a fill.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int VA_BITS     = 43;
  localparam int PA_BITS     = 34;
  localparam int SMALL_COUNT = 8;
  localparam int LARGE_COUNT = 4;
  localparam int SMALL_OFFW  = 13;
  localparam int LARGE_OFFW  = 22;

  typedef struct packed {
    logic hit;
    logic miss;
  } xl_status_t;
endpackage

// File: rtl/itb_nlu_pick.sv
module itb_nlu_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [IW-1:0] last_idx,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] victim
);
  logic found;

  always_comb begin
    found  = 1'b0;
    victim = ptr;
    for (int i = 0; i < N; i++) begin
      if (!found && !vld[i]) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    end
    if (!found && ptr == last_idx)
      victim = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/itb_cam_array.sv
module itb_cam_array #(
  parameter int N     = 8,
  parameter int TAG_W = 30,
  parameter int PFN_W = 21,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             lkp_valid,
  input  logic [TAG_W-1:0] lkp_tag,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn
);
  logic [N-1:0]     vld;
  logic [TAG_W-1:0] tag_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  logic [N-1:0]     match;
  logic [IW-1:0]    hit_idx;
  logic [IW-1:0]    last_idx;
  logic [IW-1:0]    ptr;
  logic [IW-1:0]    victim;
  logic [IW-1:0]    victim_next;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_q[g] == lkp_tag);
  end

  always_comb begin
    hit_pfn = '0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_idx = IW'(i);
      end
    end
  end
  assign hit = |match;

  itb_nlu_pick #(.N(N), .IW(IW)) u_pick (
    .vld      (vld),
    .last_idx (last_idx),
    .ptr      (ptr),
    .victim   (victim)
  );

  assign victim_next = (victim == IW'(N - 1)) ? '0 : victim + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld      <= '0;
      last_idx <= '0;
      ptr      <= '0;
    end else begin
      if (lkp_valid && hit)
        last_idx <= hit_idx;
      if (fill_en) begin
        vld[victim] <= 1'b1;
        last_idx    <= victim;
        if (&vld)
          ptr <= victim_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[victim] <= fill_tag;
      pfn_q[victim] <= fill_pfn;
    end
  end

  // input assumption: no page is present twice in one array
  p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
  p_fill_empty_first_r6: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush && !(&vld)) |-> !vld[victim]);
  p_victim_skips_last_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush && (&vld)) |-> (victim != last_idx));
endmodule

// File: rtl/instr_xlate_buf.sv
module instr_xlate_buf
  import itb_pkg::*;
#(
  parameter int VA_W      = VA_BITS,
  parameter int PA_W      = PA_BITS,
  parameter int S_ENTRIES = SMALL_COUNT,
  parameter int L_ENTRIES = LARGE_COUNT,
  parameter int S_OFF     = SMALL_OFFW,
  parameter int L_OFF     = LARGE_OFFW,
  localparam int VPN_W    = VA_W - S_OFF,
  localparam int SPFN_W   = PA_W - S_OFF,
  localparam int LTAG_W   = VA_W - L_OFF,
  localparam int LPFN_W   = PA_W - L_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [VA_W-1:0]   lkp_va,
  input  logic              fill_en,
  input  logic              fill_large,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [SPFN_W-1:0] fill_pfn,
  input  logic              flush_all,
  output logic              xl_hit,
  output logic              xl_miss,
  output logic [PA_W-1:0]   xl_pa
);
  logic              s_hit, l_hit;
  logic [SPFN_W-1:0] s_pfn;
  logic [LPFN_W-1:0] l_pfn;
  logic [PA_W-1:0]   pa_d;
  xl_status_t        st_d;

  itb_cam_array #(.N(S_ENTRIES), .TAG_W(VPN_W), .PFN_W(SPFN_W)) u_small (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_all),
    .fill_en   (fill_en && !fill_large),
    .fill_tag  (fill_vpn),
    .fill_pfn  (fill_pfn),
    .lkp_valid (lkp_valid),
    .lkp_tag   (lkp_va[VA_W-1:S_OFF]),
    .hit       (s_hit),
    .hit_pfn   (s_pfn)
  );

  itb_cam_array #(.N(L_ENTRIES), .TAG_W(LTAG_W), .PFN_W(LPFN_W)) u_large (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_all),
    .fill_en   (fill_en && fill_large),
    .fill_tag  (fill_vpn[VPN_W-1 -: LTAG_W]),
    .fill_pfn  (fill_pfn[SPFN_W-1 -: LPFN_W]),
    .lkp_valid (lkp_valid),
    .lkp_tag   (lkp_va[VA_W-1:L_OFF]),
    .hit       (l_hit),
    .hit_pfn   (l_pfn)
  );

  always_comb begin
    st_d.hit  = lkp_valid && (s_hit || l_hit);
    st_d.miss = lkp_valid && !(s_hit || l_hit);
    if (!lkp_valid)
      pa_d = '0;
    else if (l_hit)
      pa_d = {l_pfn, lkp_va[L_OFF-1:0]};
    else if (s_hit)
      pa_d = {s_pfn, lkp_va[S_OFF-1:0]};
    else
      pa_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_hit  <= 1'b0;
      xl_miss <= 1'b0;
      xl_pa   <= '0;
    end else begin
      xl_hit  <= st_d.hit;
      xl_miss <= st_d.miss;
      xl_pa   <= pa_d;
    end
  end

  p_hit_miss_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(xl_hit && xl_miss));
  p_pa_zero_unless_hit_r9: assert property (@(posedge clk) disable iff (rst)
    !xl_hit |-> (xl_pa == '0));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> (!xl_hit && !xl_miss));
  p_answer_follows_lookup_r4: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> (xl_hit || xl_miss));
endmodule

// File: tb/instr_xlate_buf_bench.sv
`timescale 1ns/1ps
module instr_xlate_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [42:0] lkp_va = '0;
  logic        fill_en = 1'b0;
  logic        fill_large = 1'b0;
  logic [29:0] fill_vpn = '0;
  logic [20:0] fill_pfn = '0;
  logic        flush_all = 1'b0;
  logic        xl_hit, xl_miss;
  logic [33:0] xl_pa;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  instr_xlate_buf u_instr_xlate_buf (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_va(lkp_va),
    .fill_en(fill_en), .fill_large(fill_large), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .flush_all(flush_all),
    .xl_hit(xl_hit), .xl_miss(xl_miss), .xl_pa(xl_pa)
  );

  // reference model: index 0 = 8 KB array, 1 = 4 MB array
  bit          m_v [2][8];
  logic [29:0] m_t [2][8];
  logic [20:0] m_p [2][8];
  int          m_last [2];
  int          m_ptr  [2];
  int          m_n    [2] = '{8, 4};
  logic        e_hit = 0, e_miss = 0;
  logic [33:0] e_pa = '0;

  always @(posedge clk) begin
    if (rst) begin
      e_hit = 0; e_miss = 0; e_pa = '0;
      for (int k = 0; k < 2; k++) begin
        m_last[k] = 0; m_ptr[k] = 0;
        for (int i = 0; i < 8; i++) m_v[k][i] = 0;
      end
    end else begin
      bit hk [2];
      int ik [2];
      logic [29:0] key [2];
      key[0] = lkp_va[42:13];
      key[1] = {9'h0, lkp_va[42:22]};
      for (int k = 0; k < 2; k++) begin
        hk[k] = 0; ik[k] = 0;
        for (int i = 0; i < m_n[k]; i++)
          if (m_v[k][i] && m_t[k][i] == key[k]) begin hk[k] = 1; ik[k] = i; end
      end
      e_hit  = lkp_valid && (hk[0] || hk[1]);
      e_miss = lkp_valid && !(hk[0] || hk[1]);
      if (!lkp_valid) e_pa = '0;
      else if (hk[1]) e_pa = {m_p[1][ik[1]][11:0], lkp_va[21:0]};
      else if (hk[0]) e_pa = {m_p[0][ik[0]], lkp_va[12:0]};
      else e_pa = '0;
      if (flush_all) begin
        for (int k = 0; k < 2; k++) begin
          m_last[k] = 0; m_ptr[k] = 0;
          for (int i = 0; i < 8; i++) m_v[k][i] = 0;
        end
      end else begin
        for (int k = 0; k < 2; k++)
          if (lkp_valid && hk[k]) m_last[k] = ik[k];
        if (fill_en) begin
          int k, v;
          bit got;
          k = fill_large ? 1 : 0;
          got = 0; v = 0;
          for (int i = 0; i < m_n[k]; i++)
            if (!got && !m_v[k][i]) begin v = i; got = 1; end
          if (!got) begin
            v = m_ptr[k];
            if (v == m_last[k]) v = (v + 1) % m_n[k];
            m_ptr[k] = (v + 1) % m_n[k];
          end
          m_v[k][v] = 1;
          m_last[k] = v;
          m_t[k][v] = fill_large ? {9'h0, fill_vpn[29:9]} : fill_vpn;
          m_p[k][v] = fill_large ? {9'h0, fill_pfn[20:9]} : fill_pfn;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (xl_hit !== e_hit || xl_miss !== e_miss || xl_pa !== e_pa) begin
        fails++;
        $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b miss=%0b pa=%h",
                 cur_req, xl_hit, xl_miss, xl_pa, e_hit, e_miss, e_pa);
      end
    end
  end

  task automatic step(input logic lv, input logic [42:0] va,
                      input logic fe, input logic fl, input logic [29:0] vpn,
                      input logic [20:0] pfn, input logic fx);
    @(negedge clk);
    lkp_valid = lv; lkp_va = va; fill_en = fe; fill_large = fl;
    fill_vpn = vpn; fill_pfn = pfn; flush_all = fx;
  endtask
  task automatic look(input logic [42:0] va); step(1, va, 0, 0, '0, '0, 0); endtask
  task automatic fill_s(input logic [29:0] vpn, input logic [20:0] pfn);
    step(0, '0, 1, 0, vpn, pfn, 0);
  endtask
  task automatic fill_l(input logic [20:0] tag, input logic [11:0] pfn);
    step(0, '0, 1, 1, {tag, 9'h0}, {pfn, 9'h0}, 0);
  endtask
  task automatic flush(); step(0, '0, 0, 0, '0, '0, 1); endtask
  task automatic idle(); step(0, '0, 0, 0, '0, '0, 0); endtask

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [29:0] s_hist [64];
    logic [20:0] l_hist [64];
    int ns, nl;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: empty after reset
    cur_req = "R1";
    look(43'h123_4567_89AB); look('0); idle();
    // R2: small pages
    cur_req = "R2";
    for (int i = 0; i < 6; i++) fill_s(30'h100 + 30'(i), 21'h1000 + 21'(i));
    for (int i = 0; i < 6; i++) look({30'h100 + 30'(i), 13'(i * 911)});
    // R3: large pages
    cur_req = "R3";
    for (int j = 0; j < 3; j++) fill_l(21'h40 + 21'(j), 12'hA0 + 12'(j));
    for (int j = 0; j < 3; j++) look({21'h40 + 21'(j), 22'(j * 77777)});
    // R4: misses and idle cycles
    cur_req = "R4";
    look({30'h3FF_FFFF, 13'h5}); idle(); look({21'h7, 22'h1}); idle();
    // R5: overlapping pages
    cur_req = "R5";
    flush();
    fill_s({21'h55, 9'h3}, 21'h0ABCD);
    look({21'h55, 9'h3, 13'h44});
    fill_l(21'h55, 12'h777);
    look({21'h55, 9'h3, 13'h44}); look({21'h55, 9'h9, 13'h1});
    // R6: empty slots reused first
    cur_req = "R6";
    flush();
    for (int i = 0; i < 5; i++) fill_s(30'h200 + 30'(i), 21'h200 + 21'(i));
    for (int i = 0; i < 5; i++) look({30'h200 + 30'(i), 13'h0});
    // R7: replacement skipping last used
    cur_req = "R7";
    flush();
    for (int i = 0; i < 8; i++) fill_s(30'h300 + 30'(i), 21'h300 + 21'(i));
    fill_s(30'h308, 21'h308);
    look({30'h301, 13'h1});
    fill_s(30'h309, 21'h309);
    for (int i = 0; i < 10; i++) look({30'h300 + 30'(i), 13'h2});
    for (int j = 0; j < 6; j++) fill_l(21'h90 + 21'(j), 12'h90 + 12'(j));
    look({21'h95, 22'h0}); fill_l(21'h96, 12'h96);
    for (int j = 0; j < 7; j++) look({21'h90 + 21'(j), 22'h3});
    // R8: flush drops a simultaneous fill
    cur_req = "R8";
    step(0, '0, 1, 0, 30'h400, 21'h400, 1);
    look({30'h400, 13'h0}); look({30'h301, 13'h0}); look({21'h95, 22'h0});
    // R10: lookup sees pre-fill contents
    cur_req = "R10";
    step(1, {30'h500, 13'h9}, 1, 0, 30'h500, 21'h500, 0);
    look({30'h500, 13'h9});
    step(1, {30'h500, 13'h9}, 0, 0, '0, '0, 1);
    look({30'h500, 13'h9});
    // R9: random mix
    cur_req = "R9";
    ns = 0; nl = 0;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 2 && ns < 64) begin
        s_hist[ns] = 30'h1000 + 30'(ns);
        fill_s(s_hist[ns], 21'($urandom)); ns++;
      end else if (r < 3 && nl < 64) begin
        l_hist[nl] = 21'h800 + 21'(nl);
        fill_l(l_hist[nl], 12'($urandom)); nl++;
      end else if (r < 10 && ns > 0) begin
        look({s_hist[$urandom_range(0, ns - 1)], 13'($urandom)});
      end else if (r < 15 && nl > 0) begin
        look({l_hist[$urandom_range(0, nl - 1)], 22'($urandom)});
      end else if (r == 15) begin
        look(43'({$urandom, $urandom}));
      end else if (r == 16 && $urandom_range(0, 9) == 0) begin
        flush();
      end else begin
        idle();
      end
    end
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule